// File: doc/BRIEF.md
# Ping-Pong Audio Sample Fetch Engine

This block feeds a serial audio transmitter with stereo samples that it reads from memory. Software describes two buffers, each with a byte base address and a length counted in stereo samples. Writing a description marks that buffer as holding data. The engine reads 32-bit words through a request/grant port with in-order returns. It keeps them in a small prefetch FIFO and hands out one left word and one right word on every sample strobe. When a buffer has been read to its end, the engine marks it as drained and moves on to the other buffer.

Four sticky status flags report what happened: buffer 0 drained, buffer 1 drained, a bandwidth miss (the FIFO could not supply a sample in time) and an underrun (no filled buffer was available when a switch was due). Each flag has an interrupt enable and a write-one acknowledge. A single interrupt line combines them. Every accepted sample strobe also starts a stretched pulse on an event output, for an external timestamp counter.

Top module: `audio_dma_out`

## Requirements
- R1: On a sample strobe with at least two words in the FIFO, `left_out` takes the word read from the lower address and `right_out` takes the word after it. Both outputs change, and `sample_valid` pulses for one cycle, in the cycle after the strobe.
- R2: A buffer with base B and length L (L of 1 or more) is read as 2*L words at B, B+4, … in order. After its last word is accepted, that buffer's drained flag is set (status bit 0 for buffer 0, bit 1 for buffer 1), its filled mark is cleared, and reading moves to the other buffer.
- R3: If the other buffer is not marked filled when a switch is due, status bit 3 (underrun) is set. The engine still moves to the other buffer slot, but it reads the data of the buffer just finished again from its start.
- R4: A sample strobe that arrives while the FIFO holds fewer than two words sets status bit 2 (bandwidth miss). `left_out` and `right_out` then repeat their previous values.
- R5: A status flag stays set until the matching bit of `ack` is high. It reads low in the cycle after that acknowledge.
- R6: When a flag is set by hardware in the same cycle as its acknowledge, the flag stays set.
- R7: `irq` is high exactly when some status bit and the matching `int_en` bit are both high.
- R8: A sample strobe while enabled drives `event_out` high from the next cycle for EVT_CYCLES cycles. A strobe while disabled has no effect on the outputs, the flags or the event.
- R9: `rd_req` is high while the engine is enabled, a buffer is loaded, and the FIFO plus outstanding reads leave room for one more word. It is never high while the engine is disabled.
- R10: Disabling the engine empties the FIFO, discards read data still in flight, and makes the next enable start again from buffer 0.
- R11: After reset, all status flags, `irq`, `event_out`, `sample_valid`, `rd_req` and both sample outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine run control; low stops fetching and empties the FIFO |
| desc_wr | input | 1 | Strobe that writes a buffer description and marks the buffer filled |
| desc_sel | input | 1 | Buffer selected by `desc_wr` (0 or 1) |
| desc_base | input | ADDR_W | Byte base address of the buffer |
| desc_len | input | LEN_W | Buffer length in stereo samples (1 or more) |
| int_en | input | 4 | Interrupt enable for each status bit |
| ack | input | 4 | Write-one clear for each status bit |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_gnt | input | 1 | Grant; a request is accepted when it is high together with `rd_req` |
| rd_valid | input | 1 | Read data return strobe, in request order |
| rd_data | input | DATA_W | Returned word |
| sample_due | input | 1 | Sample strobe from the transmitter |
| left_out | output | DATA_W | Left channel word |
| right_out | output | DATA_W | Right channel word |
| sample_valid | output | 1 | One-cycle pulse after each accepted sample strobe |
| status | output | 4 | Sticky flags: [0] buffer 0 drained, [1] buffer 1 drained, [2] bandwidth miss, [3] underrun |
| irq | output | 1 | Combined interrupt |
| event_out | output | 1 | Stretched pulse for each accepted sample |

## Verification
The bench uses two buffers of different lengths, so a word taken from the wrong buffer, the wrong offset or in swapped channel order shows up as a value mismatch. The memory model returns the inverted address as data, so every output word names its own source. Letting the stream run past both buffers separates a correct replay of the last buffer from stale FIFO contents or a stall. Holding the grant low after a disable empties the FIFO. A strobe in that state, given together with a bandwidth-miss acknowledge, tells the repeat path and the set-over-acknowledge priority apart from a plain read. The first sample after the grant returns shows whether the flush really restarted from buffer 0.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
    localparam int FLAG_N       = 4;
    localparam int FLG_EMPTY0   = 0;
    localparam int FLG_EMPTY1   = 1;
    localparam int FLG_BWMISS   = 2;
    localparam int FLG_UNDERRUN = 3;
endpackage

// File: rtl/adma_fifo.sv
module adma_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop2,
    output logic [W-1:0]                 head0,
    output logic [W-1:0]                 head1,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] rd_next;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push) begin
                st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
            end
            if (pop2) begin
                st_d.rd_ptr = st_q.rd_ptr + PTR_W'(2);
            end
            st_d.cnt = st_q.cnt + (push ? CNT_W'(1) : CNT_W'(0))
                                - (pop2 ? CNT_W'(2) : CNT_W'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    assign rd_next = st_q.rd_ptr + PTR_W'(1);
    assign head0   = mem_q[st_q.rd_ptr];
    assign head1   = mem_q[rd_next];
    assign count   = st_q.cnt;
endmodule

// File: rtl/adma_fetch.sv
module adma_fetch #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              desc_wr,
    input  logic              desc_sel,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              room,
    input  logic              rd_gnt,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        empty_set,
    output logic              underrun_set
);
    localparam int IDX_W = LEN_W + 1;

    typedef struct packed {
        logic [1:0][ADDR_W-1:0] base;
        logic [1:0][LEN_W-1:0]  len;
        logic [1:0]             filled;
        logic                   slot;
        logic                   loaded;
        logic                   replay;
        logic [ADDR_W-1:0]      src_base;
        logic [LEN_W-1:0]       src_len;
        logic [IDX_W-1:0]       widx;
    } fetch_st_t;

    fetch_st_t st_d, st_q;
    logic              accept;
    logic              nslot;
    logic [IDX_W-1:0]  last_idx;

    assign rd_req   = enable && st_q.loaded && room;
    assign rd_addr  = st_q.src_base + ADDR_W'({st_q.widx, 2'b00});
    assign accept   = rd_req && rd_gnt;
    assign nslot    = ~st_q.slot;
    assign last_idx = {st_q.src_len, 1'b0} - IDX_W'(1);

    always_comb begin
        st_d         = st_q;
        empty_set    = 2'b00;
        underrun_set = 1'b0;
        if (!enable) begin
            st_d.loaded = 1'b0;
            st_d.slot   = 1'b0;
            st_d.replay = 1'b0;
            st_d.widx   = '0;
        end else if (!st_q.loaded) begin
            if (st_q.filled[st_q.slot]) begin
                st_d.loaded   = 1'b1;
                st_d.replay   = 1'b0;
                st_d.widx     = '0;
                st_d.src_base = st_q.base[st_q.slot];
                st_d.src_len  = st_q.len[st_q.slot];
            end
        end else if (accept) begin
            if (st_q.widx == last_idx) begin
                st_d.widx = '0;
                if (!st_q.replay) begin
                    st_d.filled[st_q.slot] = 1'b0;
                    empty_set[st_q.slot]   = 1'b1;
                end
                st_d.slot = nslot;
                if (st_q.filled[nslot]) begin
                    st_d.src_base = st_q.base[nslot];
                    st_d.src_len  = st_q.len[nslot];
                    st_d.replay   = 1'b0;
                end else begin
                    underrun_set = 1'b1;
                    st_d.replay  = 1'b1;
                end
            end else begin
                st_d.widx = st_q.widx + IDX_W'(1);
            end
        end
        if (desc_wr) begin
            st_d.base[desc_sel]   = desc_base;
            st_d.len[desc_sel]    = desc_len;
            st_d.filled[desc_sel] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/adma_status.sv
module adma_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] int_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~ack) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & int_en);
endmodule

// File: rtl/adma_evt.sv
module adma_evt #(
    parameter int EVT_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic evt
);
    localparam int CNT_W = $clog2(EVT_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trig) begin
            cnt_d = CNT_W'(EVT_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign evt = (cnt_q != '0);
endmodule

// File: rtl/audio_dma_out.sv
module audio_dma_out
    import audio_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 8,
    parameter int EVT_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              desc_wr,
    input  logic              desc_sel,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [3:0]        int_en,
    input  logic [3:0]        ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_gnt,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              sample_due,
    output logic [DATA_W-1:0] left_out,
    output logic [DATA_W-1:0] right_out,
    output logic              sample_valid,
    output logic [3:0]        status,
    output logic              irq,
    output logic              event_out
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  pending;
        logic [CNT_W-1:0]  stale;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
        logic              svalid;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CNT_W-1:0]  fifo_count;
    logic [DATA_W-1:0] head0, head1;
    logic              take, have_pair, pop2, push, room, accept;
    logic [1:0]        empty_set;
    logic              underrun_set;
    logic [FLAG_N-1:0] flag_set;

    assign take      = enable && sample_due;
    assign have_pair = (fifo_count >= CNT_W'(2));
    assign pop2      = take && have_pair;
    assign push      = rd_valid && enable && (st_q.stale == '0);
    assign accept    = rd_req && rd_gnt;
    assign room      = ({1'b0, fifo_count} + {1'b0, st_q.pending}) < (CNT_W+1)'(DEPTH);

    always_comb begin
        st_d        = st_q;
        st_d.svalid = take;
        st_d.pending = st_q.pending + (accept   ? CNT_W'(1) : CNT_W'(0))
                                    - (rd_valid ? CNT_W'(1) : CNT_W'(0));
        if (!enable) begin
            st_d.stale = st_d.pending;
        end else if (rd_valid && (st_q.stale != '0)) begin
            st_d.stale = st_q.stale - CNT_W'(1);
        end
        if (pop2) begin
            st_d.left  = head0;
            st_d.right = head1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        flag_set               = '0;
        flag_set[FLG_EMPTY0]   = empty_set[0];
        flag_set[FLG_EMPTY1]   = empty_set[1];
        flag_set[FLG_BWMISS]   = take && !have_pair;
        flag_set[FLG_UNDERRUN] = underrun_set;
    end

    adma_fifo #(.DEPTH(DEPTH), .W(DATA_W)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!enable),
        .push      (push),
        .push_data (rd_data),
        .pop2      (pop2),
        .head0     (head0),
        .head1     (head1),
        .count     (fifo_count)
    );

    adma_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) fetch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .desc_wr      (desc_wr),
        .desc_sel     (desc_sel),
        .desc_base    (desc_base),
        .desc_len     (desc_len),
        .room         (room),
        .rd_gnt       (rd_gnt),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .empty_set    (empty_set),
        .underrun_set (underrun_set)
    );

    adma_status #(.N(FLAG_N)) status_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (flag_set),
        .ack    (ack),
        .int_en (int_en),
        .flags  (status),
        .irq    (irq)
    );

    adma_evt #(.EVT_CYCLES(EVT_CYCLES)) evt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (take),
        .evt   (event_out)
    );

    assign left_out     = st_q.left;
    assign right_out    = st_q.right;
    assign sample_valid = st_q.svalid;
endmodule

// File: rtl/audio_dma_out_chk.sv
module audio_dma_out_chk #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 8,
    parameter int EVT_CYCLES = 50,
    parameter int CNT_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              sample_due,
    input logic [3:0]        ack,
    input logic [3:0]        status,
    input logic [3:0]        flag_set,
    input logic              rd_req,
    input logic              event_out,
    input logic [DATA_W-1:0] left_out,
    input logic [DATA_W-1:0] right_out,
    input logic [CNT_W-1:0]  fifo_count
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (event_out) begin
            if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
        end else begin
            hi_cnt <= '0;
        end
    end

    a_r10_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~ack)) == $past(status & ~ack)));

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(ack & ~flag_set)) == 4'b0000));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(flag_set)) == $past(flag_set)));

    a_r9_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !rd_req);

    a_r4_repeat_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample_due && (fifo_count < CNT_W'(2))) |=>
            (status[2] && (left_out == $past(left_out)) && (right_out == $past(right_out))));

    a_r8_event_start: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sample_due) |=> event_out);

    a_r8_event_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(event_out) |-> (hi_cnt >= 16'(EVT_CYCLES)));
endmodule

bind audio_dma_out audio_dma_out_chk #(
    .DATA_W     (DATA_W),
    .DEPTH      (DEPTH),
    .EVT_CYCLES (EVT_CYCLES),
    .CNT_W      (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sample_due (sample_due),
    .ack        (ack),
    .status     (status),
    .flag_set   (flag_set),
    .rd_req     (rd_req),
    .event_out  (event_out),
    .left_out   (left_out),
    .right_out  (right_out),
    .fifo_count (fifo_count)
);

// File: tb/audio_dma_out_tb_top.sv
module audio_dma_out_tb_top;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DATA_W = 32;
    localparam int EVT_N  = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              desc_wr = 1'b0;
    logic              desc_sel = 1'b0;
    logic [ADDR_W-1:0] desc_base = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic [3:0]        int_en = '0;
    logic [3:0]        ack = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_gnt;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              sample_due = 1'b0;
    logic [DATA_W-1:0] left_out, right_out;
    logic              sample_valid;
    logic [3:0]        status;
    logic              irq;
    logic              event_out;

    logic              gnt_on = 1'b1;
    logic              p1_v = 1'b0, p2_v = 1'b0;
    logic [DATA_W-1:0] p1_d = '0, p2_d = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_dma_out #(.EVT_CYCLES(EVT_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .desc_wr(desc_wr), .desc_sel(desc_sel), .desc_base(desc_base), .desc_len(desc_len),
        .int_en(int_en), .ack(ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
        .sample_due(sample_due), .left_out(left_out), .right_out(right_out),
        .sample_valid(sample_valid), .status(status), .irq(irq), .event_out(event_out)
    );

    // memory model: data is the inverted byte address, two cycles of latency
    assign rd_gnt   = rd_req && gnt_on;
    assign rd_valid = p2_v;
    assign rd_data  = p2_d;

    always @(posedge clk) begin
        p1_v <= rd_req && rd_gnt;
        p1_d <= ~rd_addr;
        p2_v <= p1_v;
        p2_d <= p1_d;
    end

    function automatic logic [31:0] mem(input logic [31:0] a);
        return ~a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_desc(input logic sel, input logic [31:0] base, input logic [15:0] len);
        @(negedge clk);
        desc_wr = 1'b1; desc_sel = sel; desc_base = base; desc_len = len;
        @(negedge clk);
        desc_wr = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] ack_v);
        @(negedge clk);
        sample_due = 1'b1; ack = ack_v;
        @(negedge clk);
        sample_due = 1'b0; ack = 4'b0000;
    endtask

    task automatic do_ack(input logic [3:0] v);
        @(negedge clk);
        ack = v;
        @(negedge clk);
        ack = 4'b0000;
    endtask

    task automatic t_reset;
        chk("R11 status", 32'(status), 32'h0);
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 event", 32'(event_out), 32'h0);
        chk("R11 sample_valid", 32'(sample_valid), 32'h0);
        chk("R11 rd_req", 32'(rd_req), 32'h0);
        chk("R11 left", left_out, 32'h0);
        chk("R11 right", right_out, 32'h0);
        strobe(4'b0000);
        chk("R8 disabled strobe valid", 32'(sample_valid), 32'h0);
        chk("R8 disabled strobe event", 32'(event_out), 32'h0);
        chk("R8 disabled strobe status", 32'(status), 32'h0);
    endtask

    task automatic t_stream;
        logic [31:0] exp_base [7];
        exp_base = '{32'h1000, 32'h1008, 32'h1010, 32'h2000, 32'h2008, 32'h2000, 32'h2008};
        wr_desc(1'b0, 32'h1000, 16'd3);
        wr_desc(1'b1, 32'h2000, 16'd2);
        @(negedge clk); enable = 1'b1;
        wait_cyc(100);
        for (int s = 0; s < 7; s++) begin
            strobe(4'b0000);
            chk($sformatf("R1 valid s%0d", s), 32'(sample_valid), 32'h1);
            chk($sformatf("R2 R3 left s%0d", s), left_out, mem(exp_base[s]));
            chk($sformatf("R1 right s%0d", s), right_out, mem(exp_base[s] + 32'd4));
            if (s == 0) begin
                chk("R8 event rise", 32'(event_out), 32'h1);
                wait_cyc(EVT_N - 1);
                chk("R8 event held", 32'(event_out), 32'h1);
                wait_cyc(1);
                chk("R8 event ends", 32'(event_out), 32'h0);
            end
            wait_cyc(60);
        end
        chk("R2 R3 status after stream", 32'(status), 32'hB);
        chk("R7 irq masked", 32'(irq), 32'h0);
        @(negedge clk); int_en = 4'b0100;
        @(negedge clk);
        chk("R7 irq other bit", 32'(irq), 32'h0);
        int_en = 4'b1000;
        @(negedge clk);
        chk("R7 irq underrun", 32'(irq), 32'h1);
        wait_cyc(50);
        chk("R9 stalled when full", 32'(rd_req), 32'h0);
        do_ack(4'b1001);
        chk("R5 ack clears", 32'(status), 32'h2);
        chk("R7 irq drops", 32'(irq), 32'h0);
        do_ack(4'b0010);
        chk("R5 ack clears buf1", 32'(status), 32'h0);
    endtask

    task automatic t_starve;
        @(negedge clk); enable = 1'b0; gnt_on = 1'b0;
        wait_cyc(5);
        chk("R9 no req disabled", 32'(rd_req), 32'h0);
        wr_desc(1'b0, 32'h3000, 16'd4);
        @(negedge clk); enable = 1'b1;
        wait_cyc(10);
        chk("R9 requesting with room", 32'(rd_req), 32'h1);
        strobe(4'b0100);
        chk("R6 set beats ack", 32'(status[2]), 32'h1);
        chk("R4 repeat left", left_out, mem(32'h2008));
        chk("R4 repeat right", right_out, mem(32'h200C));
        @(negedge clk); gnt_on = 1'b1;
        wait_cyc(40);
        strobe(4'b0000);
        chk("R10 restart left", left_out, mem(32'h3000));
        chk("R10 restart right", right_out, mem(32'h3004));
        do_ack(4'b0100);
        chk("R5 bw flag cleared", 32'(status[2]), 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_stream();
        t_starve();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule